// File: doc/BRIEF.md
# Programmable Multi-Channel Logic Cell

This block holds an array of independent logic channels. Every channel receives three single-bit signals, A, B and C. A first gate merges A with B. An optional second gate then merges that partial result with C. Each of the three inputs, and the final result, has its own inversion control. The result leaves the channel through a delay line whose length is programmable per channel, and that delay line always adds at least one register stage.

Software sets up each channel through a small synchronous register bus that uses word addresses. Each channel has two registers, a configuration word and a delay word, and both read back in full. The gate codes are defined so that a partly written or nonsensical configuration still gives a well-defined output.

Top module: `logic_cell_array`

## Requirements
- R1: An active-low asynchronous reset clears every configuration and delay register, every channel output and the read-data output.
- R2: The configuration register of channel n sits at word address 0x4000+n. The delay register of channel n sits at 0x4004+n. Both hold all 32 written bits. Read data appears on the cycle after the address is presented and reflects the register contents before any write in that same cycle.
- R3: Any word address outside 0x4000..0x4007 reads as zero. A write to such an address changes no register.
- R4: Configuration bits 0, 1, 2 and 3 invert A, B, C and the final result Y respectively when set. When clear, the signal passes unchanged.
- R5: Configuration field [15:8] selects the A-B gate: 1 is OR, 2 is AND, 3 is XOR.
- R6: Configuration field [23:16] selects the gate that merges the A-B result with C. It uses the same codes (1 OR, 2 AND, 3 XOR).
- R7: When field [15:8] is 0 or an undefined code (4..255), the A-B stage is off. The pre-inversion result is then the conditioned A alone, whatever field [23:16] holds.
- R8: When the A-B stage is on and field [23:16] is 0 or an undefined code, the pre-inversion result is the A-B gate output.
- R9: The delay register bits [7:0] give D, from 0 to 255. The output Y at cycle n+1+D equals the result computed from the inputs and configuration at cycle n. Before that history exists, the output is 0.
- R10: Each channel computes and delays its result only from its own inputs and its own registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Word address |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the address |
| ch_a_i | input | 4 | Input A, one bit per channel |
| ch_b_i | input | 4 | Input B, one bit per channel |
| ch_c_i | input | 4 | Input C, one bit per channel |
| ch_y_o | output | 4 | Delayed result Y, one bit per channel |

## Verification
Exhaustive sweeps over all eight A/B/C combinations are run under every defined gate pairing. These sweeps separate OR, AND and XOR from one another and show which operand feeds each stage. Inversion masks 0 to 15 are combined with XOR gates so that every inverted signal visibly flips the result. Invalid pairings (A-B off with C set, and undefined codes) show whether C is wrongly let through. Random inputs at delays of 0, 1, 3 and 255, with the delay changed in the middle of a stream, expose off-by-one errors and wrap-around errors in the circular buffer.

// File: rtl/lca_pkg.sv
package lca_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OP_W   = 8;

  typedef enum logic [OP_W-1:0] {
    OP_OFF = 8'd0,
    OP_OR  = 8'd1,
    OP_AND = 8'd2,
    OP_XOR = 8'd3
  } op_e;

  function automatic logic op_valid(input logic [OP_W-1:0] op);
    return (op == OP_OR) || (op == OP_AND) || (op == OP_XOR);
  endfunction

  function automatic logic op_apply(input logic [OP_W-1:0] op, input logic x, input logic y);
    case (op)
      OP_OR:   return x | y;
      OP_AND:  return x & y;
      OP_XOR:  return x ^ y;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lca_reg_bank.sv
module lca_reg_bank
  import lca_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h4000
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           we_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  cfg_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  dly_o
);
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned N_REGS = 2 * NUM_CH;

  logic [ADDR_W-1:0] off;
  logic              hit;
  logic              is_dly;
  logic [CH_W-1:0]   ch_sel;
  logic [DATA_W-1:0] rd_mux;

  assign off    = addr_i - ADDR_W'(BASE_ADDR);
  assign hit    = (addr_i >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(N_REGS));
  assign is_dly = (off >= ADDR_W'(NUM_CH));
  assign ch_sel = is_dly ? CH_W'(off - ADDR_W'(NUM_CH)) : CH_W'(off);

  always_comb begin
    rd_mux = '0;
    if (hit) rd_mux = is_dly ? dly_o[ch_sel] : cfg_o[ch_sel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= '0;
      dly_o   <= '0;
      rdata_o <= '0;
    end else begin
      rdata_o <= rd_mux;
      if (we_i && hit) begin
        if (is_dly) dly_o[ch_sel] <= wdata_i;
        else        cfg_o[ch_sel] <= wdata_i;
      end
    end
  end

  // R3
  oob_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> (rdata_o == '0));
  // R3
  oob_write_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> ($stable(cfg_o) && $stable(dly_o)));
endmodule

// File: rtl/lca_gate_chain.sv
module lca_gate_chain
  import lca_pkg::*;
(
  input  logic              a_i,
  input  logic              b_i,
  input  logic              c_i,
  input  logic [DATA_W-1:0] cfg_i,
  output logic              y_o
);
  logic [OP_W-1:0] ab_op, c_op;
  logic a_c, b_c, c_c, inv_y;
  logic ab_ok, c_ok, ab_res, pre;

  assign a_c   = a_i ^ cfg_i[0];
  assign b_c   = b_i ^ cfg_i[1];
  assign c_c   = c_i ^ cfg_i[2];
  assign inv_y = cfg_i[3];
  assign ab_op = cfg_i[15:8];
  assign c_op  = cfg_i[23:16];
  assign ab_ok = op_valid(ab_op);
  assign c_ok  = op_valid(c_op);

  always_comb begin
    ab_res = op_apply(ab_op, a_c, b_c);
    if (!ab_ok)     pre = a_c;
    else if (!c_ok) pre = ab_res;
    else            pre = op_apply(c_op, ab_res, c_c);
  end

  assign y_o = pre ^ inv_y;

  always_comb begin
    // R7
    if (!ab_ok) ab_off_pass_a_chk: assert (y_o == (a_i ^ cfg_i[0] ^ cfg_i[3]));
  end
endmodule

// File: rtl/lca_delay_line.sv
module lca_delay_line #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             y_o
);
  localparam int unsigned DEPTH = 2 ** DLY_W;

  logic [DEPTH-1:0] ring_q;
  logic [DLY_W-1:0] wp_q;
  logic [DLY_W-1:0] rd_idx;

  assign rd_idx = wp_q - dly_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= '0;
      wp_q   <= '0;
      y_o    <= 1'b0;
    end else begin
      ring_q[wp_q] <= d_i;
      wp_q         <= wp_q + 1'b1;
      y_o          <= (dly_i == '0) ? d_i : ring_q[rd_idx];
    end
  end

  // R9
  zero_dly_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_i == '0) |=> (y_o == $past(d_i)));
endmodule

// File: rtl/logic_cell_array.sv
module logic_cell_array
  import lca_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h4000,
  parameter int unsigned DLY_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NUM_CH-1:0] ch_a_i,
  input  logic [NUM_CH-1:0] ch_b_i,
  input  logic [NUM_CH-1:0] ch_c_i,
  output logic [NUM_CH-1:0] ch_y_o
);
  logic [NUM_CH-1:0][DATA_W-1:0] cfg_w, dly_w;
  logic [NUM_CH-1:0]             res_w;

  lca_reg_bank #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(bus_addr_i), .we_i(bus_we_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .cfg_o(cfg_w), .dly_o(dly_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    lca_gate_chain u_gate (
      .a_i(ch_a_i[g]), .b_i(ch_b_i[g]), .c_i(ch_c_i[g]),
      .cfg_i(cfg_w[g]), .y_o(res_w[g])
    );
    lca_delay_line #(.DLY_W(DLY_W)) u_dly (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(res_w[g]),
      .dly_i(dly_w[g][DLY_W-1:0]), .y_o(ch_y_o[g])
    );
  end
endmodule

// File: tb/logic_cell_array_tb_top.sv
module logic_cell_array_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  a = '0, b = '0, c = '0;
  logic [3:0]  y;

  int   n_vec = 0, n_bad = 0;
  bit   finished = 0;
  string cur_req = "R1";

  int unsigned m_cfg[4];
  int unsigned m_dly[4];
  logic [3:0]  hq[$];
  logic [3:0]  exp_y = '0;
  logic [31:0] exp_rd = '0;

  always #4 clk = ~clk;

  logic_cell_array dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ch_a_i(a), .ch_b_i(b),
    .ch_c_i(c), .ch_y_o(y)
  );

  function automatic bit gate(int unsigned op, bit x, bit z);
    if (op == 1) return x | z;
    if (op == 2) return x & z;
    return x ^ z;
  endfunction

  function automatic bit model_res(int ch, bit av, bit bv, bit cv);
    int unsigned w = m_cfg[ch];
    int unsigned abop = (w >> 8) & 255;
    int unsigned cop = (w >> 16) & 255;
    bit ai = av ^ w[0], bi = bv ^ w[1], ci = cv ^ w[2];
    bit r;
    if (abop < 1 || abop > 3) r = ai;
    else begin
      r = gate(abop, ai, bi);
      if (cop >= 1 && cop <= 3) r = gate(cop, r, ci);
    end
    return r ^ w[3];
  endfunction

  function automatic logic [31:0] model_rd(logic [15:0] ad);
    if (ad >= 16'h4000 && ad < 16'h4008) begin
      int idx = int'(ad - 16'h4000);
      return (idx < 4) ? m_cfg[idx] : m_dly[idx-4];
    end
    return 32'h0;
  endfunction

  task automatic compare();
    n_vec++;
    if (y !== exp_y) begin
      n_bad++;
      $display("FAIL %s: ch_y_o actual=%b expected=%b at %0t", cur_req, y, exp_y, $time);
    end
    n_vec++;
    if (rdata !== exp_rd) begin
      n_bad++;
      $display("FAIL %s: bus_rdata_o actual=%h expected=%h at %0t", cur_req, rdata, exp_rd, $time);
    end
  endtask

  // one clock: check, drive, predict, advance to next falling edge
  task automatic cyc(logic [15:0] ad, bit w, logic [31:0] wd,
                     logic [3:0] av, logic [3:0] bv, logic [3:0] cv);
    logic [3:0] f;
    logic [3:0] ny;
    compare();
    addr = ad; we = w; wdata = wd; a = av; b = bv; c = cv;
    for (int ch = 0; ch < 4; ch++) f[ch] = model_res(ch, av[ch], bv[ch], cv[ch]);
    hq.push_back(f);
    if (hq.size() > 300) void'(hq.pop_front());
    for (int ch = 0; ch < 4; ch++) begin
      int d = int'(m_dly[ch] & 255);
      if (d == 0) ny[ch] = f[ch];
      else if (hq.size() > d) ny[ch] = hq[hq.size()-1-d][ch];
      else ny[ch] = 1'b0;
    end
    exp_rd = model_rd(ad);
    exp_y = ny;
    if (w && ad >= 16'h4000 && ad < 16'h4008) begin
      int idx = int'(ad - 16'h4000);
      if (idx < 4) m_cfg[idx] = wd; else m_dly[idx-4] = wd;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [15:0] ad, logic [31:0] wd);
    cyc(ad, 1'b1, wd, a, b, c);
  endtask

  task automatic sweep();
    for (int v = 0; v < 8; v++)
      cyc(16'h0, 1'b0, 32'h0, {4{v[0]}}, {4{v[1]}}, {4{v[2]}});
  endtask

  task automatic cfg_all(logic [31:0] wd);
    for (int ch = 0; ch < 4; ch++) wr(16'h4000 + 16'(ch), wd);
  endtask

  initial begin
    for (int ch = 0; ch < 4; ch++) begin m_cfg[ch] = 0; m_dly[ch] = 0; end
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) cyc(16'h4000 + 16'(i), 1'b0, 32'h0, '0, '0, '0);

    cur_req = "R2";
    for (int i = 0; i < 4; i++) wr(16'h4000 + 16'(i), 32'hA5000000 | (32'h11 << (i*4)) | 32'hF0);
    for (int i = 0; i < 4; i++) wr(16'h4004 + 16'(i), 32'hDEAD0000 | 32'(i*3));
    cyc(16'h4002, 1'b1, 32'h1234_5670, '0, '0, '0);
    for (int i = 0; i < 8; i++) cyc(16'h4000 + 16'(i), 1'b0, 32'h0, 4'h5, 4'h3, 4'h9);

    cur_req = "R3";
    wr(16'h4008, 32'hFFFF_FFFF);
    wr(16'h3FFF, 32'hFFFF_FFFF);
    wr(16'hFFFF, 32'hFFFF_FFFF);
    cyc(16'h4008, 1'b0, 32'h0, '0, '0, '0);
    cyc(16'h3FFF, 1'b0, 32'h0, '0, '0, '0);
    cyc(16'h0000, 1'b0, 32'h0, '0, '0, '0);
    for (int i = 0; i < 8; i++) cyc(16'h4000 + 16'(i), 1'b0, 32'h0, '0, '0, '0);
    for (int i = 0; i < 4; i++) wr(16'h4004 + 16'(i), 32'h0);

    cur_req = "R4";
    for (int m = 0; m < 16; m++) begin
      cfg_all(32'h0003_0300 | 32'(m));
      sweep();
    end
    cfg_all(32'h0000_0001); sweep();
    cfg_all(32'h0000_0008); sweep();

    cur_req = "R5";
    for (int op = 1; op <= 3; op++) begin cfg_all(32'(op) << 8); sweep(); end

    cur_req = "R6";
    for (int op1 = 1; op1 <= 3; op1++)
      for (int op2 = 1; op2 <= 3; op2++) begin
        cfg_all((32'(op2) << 16) | (32'(op1) << 8)); sweep();
      end

    cur_req = "R7";
    cfg_all(32'h0002_0000); sweep();
    cfg_all(32'h0001_0400); sweep();
    cfg_all(32'h0003_FF06); sweep();

    cur_req = "R8";
    cfg_all(32'h0004_0300); sweep();
    cfg_all(32'h00C8_0100); sweep();

    cur_req = "R9";
    cfg_all(32'h0000_0300);
    wr(16'h4004, 32'h1);
    wr(16'h4005, 32'h3);
    wr(16'h4006, 32'hFFFF_FFFF);
    wr(16'h4007, 32'h0);
    for (int i = 0; i < 300; i++) cyc(16'h0, 1'b0, 32'h0, 4'($urandom), 4'($urandom), 4'($urandom));
    wr(16'h4004, 32'h7);
    wr(16'h4006, 32'h2);
    for (int i = 0; i < 40; i++) cyc(16'h0, 1'b0, 32'h0, 4'($urandom), 4'($urandom), 4'($urandom));

    cur_req = "R10";
    wr(16'h4000, 32'h0001_0209);
    wr(16'h4001, 32'h0003_0106);
    wr(16'h4002, 32'h0000_0003);
    wr(16'h4003, 32'h0002_0302);
    wr(16'h4004, 32'h0); wr(16'h4005, 32'h5); wr(16'h4006, 32'h0); wr(16'h4007, 32'h2);
    for (int i = 0; i < 200; i++) cyc(16'h4000 + 16'(i % 8), 1'b0, 32'h0, 4'($urandom), 4'($urandom), 4'($urandom));
    compare();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL %s: watchdog actual=timeout expected=completion", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule